// File: doc/BRIEF.md
# Rewindable First-In/First-Out Buffer with Half-Full Status

This block is a single-clock FIFO that stores words of `DATA_W` bits (nine by default, so one bit is left over for parity or a control marker) in a ring of `DEPTH` locations (2048 by default). The producer raises `wr_en` with a word on `wr_data`, and the consumer raises `rd_en`. No address is ever supplied. An internal write position and an internal read position step through the ring in order and wrap from the last location back to location zero. A push and a pop may both be accepted in the same cycle.

Three registered flags report how full the buffer is: `empty`, `full` and `half_full`. A push while `full` is refused, and so is a pop while `empty`. Neither refused request moves a position. Holding `rewind_n` low at a clock edge sends the read position back to location zero and rebuilds the occupancy from the write position. The words written since reset can then be read out again from the first one, which suits a link that must resend a frame after an error.

`rst_n` is an asynchronous active-low reset. Its release is synchronised to `clk` inside the block.

Top module: `rewind_fifo`

## Requirements
- R1: Accepted words come out in the order they were written, with all `DATA_W` bits intact. `rd_data` takes the popped word at the clock edge that accepts the pop and holds that value until the next accepted pop.
- R2: The flags follow the occupancy count: `empty` is 1 exactly when the count is 0, `full` is 1 exactly when the count equals `DEPTH`, and `half_full` is 1 exactly when the count is greater than `DEPTH/2`. All three change at the same edge as the count.
- R3: An accepted push alone raises the count by one, and an accepted pop alone lowers it by one. When a push and a pop are both accepted in the same cycle, the count stays the same.
- R4: A push while `full` is 1 is ignored: no position moves and no stored word is overwritten.
- R5: A pop while `empty` is 1 is ignored: no position moves and `rd_data` keeps its value.
- R6: When `rewind_n` is 0 at a clock edge:
  - the read position returns to location 0;
  - the count becomes the write position (0 to `DEPTH-1`);
  - the flags follow at that same edge;
  - a push or pop requested in that cycle is ignored.
- R7: While `rst_n` is 0, both positions and the count are 0, `empty` is 1, `full` and `half_full` are 0, and `rd_data` is 0.
- R8: Both positions wrap from `DEPTH-1` to 0, so traffic of more than `DEPTH` words keeps its order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Word to push |
| rd_en | input | 1 | Pop request |
| rewind_n | input | 1 | Active-low rewind of the read position |
| rd_data | output | DATA_W | Last popped word |
| empty | output | 1 | Count is zero |
| full | output | 1 | Count equals DEPTH |
| half_full | output | 1 | Count exceeds DEPTH/2 |

## Verification
Every result in this block is due one edge after the request that causes it:
- a popped word appears on `rd_data` after the edge that accepts the pop;
- the flags take their new values at the edge where the count changes;
- a rewind shows its effect at the edge that samples `rewind_n` low.

The bench drives its inputs on the falling edge, lets one rising edge pass, and compares the outputs at the next falling edge against a ring model that it updates for that same rising edge. To cover every fill level, the sweep uses a 16-deep configuration. During reset, the outputs are checked before any clock edge, because they clear asynchronously.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  // Encoding of the accepted operations in one cycle: {pop, push}
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } rwf_op_e;
endpackage

// File: rtl/rwf_ptr_ctrl.sv
module rwf_ptr_ctrl
  import rwf_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              rewind_n,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cnt_nxt
);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
  localparam logic [ADDR_W-1:0] LAST     = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
  logic [CNT_W-1:0]  cnt_q;
  rwf_op_e           op;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] p);
    return (p == LAST) ? '0 : p + ADDR_W'(1);
  endfunction

  always_comb begin
    wr_ok  = wr_en && rewind_n && (cnt_q != FULL_CNT);
    rd_ok  = rd_en && rewind_n && (cnt_q != '0);
    op     = rwf_op_e'({rd_ok, wr_ok});
    wr_nxt = wr_q;
    rd_nxt = rd_q;
    cnt_nxt = cnt_q;
    if (!rewind_n) begin
      rd_nxt  = '0;
      cnt_nxt = {{(CNT_W-ADDR_W){1'b0}}, wr_q};
    end else begin
      case (op)
        OP_PUSH: begin
          wr_nxt  = step(wr_q);
          cnt_nxt = cnt_q + CNT_ONE;
        end
        OP_POP: begin
          rd_nxt  = step(rd_q);
          cnt_nxt = cnt_q - CNT_ONE;
        end
        OP_BOTH: begin
          wr_nxt = step(wr_q);
          rd_nxt = step(rd_q);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_nxt;
      rd_q  <= rd_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
  assign count  = cnt_q;
endmodule

// File: rtl/rwf_flags.sv
module rwf_flags #(
  parameter int DEPTH = 2048,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             empty,
  output logic             full,
  output logic             half_full
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic empty_d, full_d, half_d;

  always_comb begin
    empty_d = (cnt_nxt == '0);
    full_d  = (cnt_nxt == FULL_CNT);
    half_d  = (cnt_nxt > HALF_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty     <= 1'b1;
      full      <= 1'b0;
      half_full <= 1'b0;
    end else begin
      empty     <= empty_d;
      full      <= full_d;
      half_full <= half_d;
    end
  end
endmodule

// File: rtl/rwf_store.sv
module rwf_store #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 9,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ok,
  input  logic [ADDR_W-1:0] rd_ptr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] q_d;

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wr_ptr] <= wr_data;
    end
  end

  always_comb begin
    q_d = rd_data;
    if (rd_ok) begin
      q_d = mem[rd_ptr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      rd_data <= q_d;
    end
  end
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rewind_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              half_full
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = ADDR_W + 1;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              wr_ok, rd_ok;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count, cnt_nxt;

  // Reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  rwf_ptr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rewind_n (rewind_n),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .count    (count),
    .cnt_nxt  (cnt_nxt)
  );

  rwf_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cnt_nxt   (cnt_nxt),
    .empty     (empty),
    .full      (full),
    .half_full (half_full)
  );

  rwf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_ok   (wr_ok),
    .wr_ptr  (wr_ptr),
    .wr_data (wr_data),
    .rd_ok   (rd_ok),
    .rd_ptr  (rd_ptr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/rewind_fifo_chk.sv
module rewind_fifo_chk #(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              rewind_n,
  input logic              empty,
  input logic              full,
  input logic              half_full,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [ADDR_W-1:0] rd_ptr,
  input logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && rewind_n) |=> (wr_ptr == $past(wr_ptr)));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && rewind_n) |=> (rd_ptr == $past(rd_ptr)));

  // R6
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rewind_n) |=> (rd_ptr == '0 && count == {1'b0, $past(wr_ptr)}));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_n |=> (count == $past(count) || count == $past(count) + ONE
                  || count == $past(count) - ONE));

  // R2
  flag_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && (full || half_full)) && (!full || half_full));

  // R2
  empty_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (count == '0));
endmodule

bind rewind_fifo rewind_fifo_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .rewind_n  (rewind_n),
  .empty     (empty),
  .full      (full),
  .half_full (half_full),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr),
  .count     (count)
);

// File: tb/rewind_fifo_test.sv
module rewind_fifo_test;
  localparam int DW = 9;
  localparam int D  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, rewind_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          empty, full, half_full;

  int checks = 0, fails = 0;
  bit done = 0;

  // ring model
  logic [DW-1:0] m_mem [D];
  int m_wp, m_rp, m_cnt;
  logic [DW-1:0] m_q;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  rewind_fifo #(.DATA_W(DW), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rewind_n(rewind_n), .rd_data(rd_data),
    .empty(empty), .full(full), .half_full(half_full)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R1 rd_data"}, int'(rd_data), int'(m_q));
    check({tag, " R2 empty"}, int'(empty), int'(m_cnt == 0));
    check({tag, " R2 full"}, int'(full), int'(m_cnt == D));
    check({tag, " R2 half_full"}, int'(half_full), int'(m_cnt > D / 2));
  endtask

  task automatic model_reset();
    m_wp = 0; m_rp = 0; m_cnt = 0; m_q = '0;
  endtask

  // drive at negedge, one rising edge, compare at next negedge
  task automatic cycle(input bit w, input logic [DW-1:0] wd, input bit r,
                       input bit rw_n, input string tag);
    bit wa, ra;
    wr_en = w; wr_data = wd; rd_en = r; rewind_n = rw_n;
    @(posedge clk);
    if (!rw_n) begin
      m_rp = 0;
      m_cnt = m_wp;
    end else begin
      wa = w && (m_cnt < D);
      ra = r && (m_cnt > 0);
      if (ra) begin
        m_q = m_mem[m_rp];
        m_rp = (m_rp + 1) % D;
      end
      if (wa) begin
        m_mem[m_wp] = wd;
        m_wp = (m_wp + 1) % D;
      end
      m_cnt = m_cnt + int'(wa) - int'(ra);
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0; rewind_n = 1;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    #1;
    model_reset();
    check_all("R7 reset");
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_all("R7 after release");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();

    // R5: pop while empty ignored
    cycle(0, '0, 1, 1, "R5 pop empty");

    // R2/R3: fill to full, flags at every level
    for (int i = 0; i < D; i++) cycle(1, DW'(i * 37 + 5), 0, 1, "R3 fill");
    // R4: push while full ignored
    cycle(1, 9'h1FF, 0, 1, "R4 push full");
    cycle(1, 9'h155, 0, 1, "R4 push full again");
    // R3: simultaneous push and pop while full: pop accepted only
    cycle(1, 9'h0AA, 1, 1, "R3 both at full");
    // drain five
    for (int i = 0; i < 5; i++) cycle(0, '0, 1, 1, "R1 drain");
    // R3: simultaneous push and pop keep count
    for (int i = 0; i < 6; i++) cycle(1, DW'(300 + i), 1, 1, "R3 both");
    // R8: wrap by continuing traffic
    for (int i = 0; i < 4; i++) cycle(1, DW'(400 + i), 0, 1, "R8 wrap push");
    for (int i = 0; i < D + 2; i++) cycle(0, '0, 1, 1, "R8 drain past empty");

    // R6: rewind replay after fresh reset
    do_reset();
    for (int i = 0; i < 7; i++) cycle(1, DW'(i * 61 + 1), 0, 1, "R6 load");
    for (int i = 0; i < 7; i++) cycle(0, '0, 1, 1, "R6 first pass");
    cycle(1, 9'h1F0, 1, 0, "R6 rewind ignores push/pop");
    for (int i = 0; i < 8; i++) cycle(0, '0, 1, 1, "R6 replay");
    cycle(0, '0, 0, 0, "R6 rewind again");
    for (int i = 0; i < 3; i++) cycle(0, '0, 1, 1, "R6 partial replay");
    // R6: rewind with 10 stored crosses half_full
    for (int i = 0; i < 3; i++) cycle(1, DW'(i + 90), 0, 1, "R6 add");
    cycle(0, '0, 0, 0, "R6 rewind half_full");

    // mixed pseudo-random traffic over all levels and wraps
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[0] | lfsr[3], DW'(lfsr[11:3]), lfsr[1] & (lfsr[5] | (i > 1500)),
            !(lfsr[15:9] == 7'h3F), "R1 mixed");
    end

    // R7: reset in the middle of traffic
    for (int i = 0; i < 5; i++) cycle(1, DW'(i), 0, 1, "R7 preload");
    do_reset();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule